// File: doc/BRIEF.md
# USB Host Schedule Traversal Sequencer

This block decides, micro-frame by micro-frame, which host schedule is walked and which memory words are read. On each micro-frame tick it builds the address of one frame list entry from the periodic base register and the frame index. It reads that entry and follows next-link pointers through the periodic structures until it reads a link whose terminate bit is set. It then switches, with no idle cycle, to the asynchronous queue-head list. It walks that list until the next tick.

Each fetched structure contributes one word, its next-link pointer. A link's target is its bits 31:5 with bits 4:0 cleared, and bit 0 is the terminate flag. During the asynchronous walk the block keeps its own copy of the queue-head pointer and advances it with every link it reads. The next micro-frame therefore resumes where the previous one stopped. Software can overwrite that pointer through a write strobe. Memory is reached through a single read port with a valid/ready request and a one-cycle response strobe. Only one read is ever outstanding.

Top module: `usb_sched_walker`

## Requirements
- R1: After reset `rd_valid` is 0, `phase` is 0 (idle) and `async_ptr` is 0.
- R2: A tick with `per_en` high makes the next cycle show `phase` = 1 (periodic) and a read request at `{per_base[31:12], frindex[12:3], 2'b00}`. Base bits 11:0 and frindex bits 13 and 2:0 play no part.
- R3: In the periodic phase, a response with bit 0 clear causes the next read at `{rsp_data[31:5], 5'b00000}`.
- R4: A periodic response with bit 0 set ends the periodic walk. If `async_en` is high, the very next cycle raises `rd_valid` with `rd_addr` equal to `async_ptr` and `phase` = 2 (async). Otherwise the block goes idle.
- R5: Each asynchronous response loads `async_ptr` with `{rsp_data[31:5], 5'b00000}`, and the walk continues at that address until a tick arrives. The walk also stops if `async_en` is low when a response returns.
- R6: A tick aborts any traversal in progress and restarts at the frame list entry derived from the current inputs.
- R7: A tick with `per_en` low and `async_en` high starts the async phase directly at `async_ptr`.
- R8: A tick with both enables low issues no read and leaves `phase` at 0.
- R9: `async_wr` loads `async_ptr` with `{async_wdata[31:5], 5'b00000}` on the next cycle and takes priority over the walk's own update.
- R10: At most one read is outstanding: after a handshake `rd_valid` drops until the response arrives. An unaccepted request holds its address.
- R11: The response to a read that a tick abandoned is discarded. It neither advances `async_ptr` nor steers the new walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| uframe_tick | input | 1 | Start-of-micro-frame pulse |
| per_en | input | 1 | Periodic schedule enable |
| async_en | input | 1 | Asynchronous schedule enable |
| per_base | input | 32 | Periodic frame list base (bits 31:12 used) |
| frindex | input | 14 | Frame index counter |
| async_wr | input | 1 | Write strobe for the queue-head pointer |
| async_wdata | input | 32 | Value written to the queue-head pointer |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | 32 | Read address |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | 32 | Read data (a next-link pointer) |
| phase | output | 2 | 0 idle, 1 periodic, 2 async |
| async_ptr | output | 32 | Current async queue-head pointer |

## Verification
The bench aims at the handover from periodic to async. A design that idled there, or that started at a stale pointer, shows a wrong gap between the handshakes or a wrong first async address. Frame list addresses are tried with junk in the ignored base and index bits, which exposes a wrong concatenation or a shift by one. A tick is thrown in while a slow read is in flight. A design that used the late response would advance the queue-head pointer or fetch from the old chain instead of the new entry. Stalled requests and the enable combinations, with no read at all when both are off, complete the set.

// File: rtl/usbw_pkg.sv
package usbw_pkg;
  localparam int ADDR_W   = 32;
  localparam int FIDX_W   = 14;
  localparam int LINK_LSB = 5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PER_REQ, ST_PER_WAIT, ST_ASY_REQ, ST_ASY_WAIT
  } walk_st_t;

  localparam logic [1:0] PH_IDLE  = 2'd0;
  localparam logic [1:0] PH_PER   = 2'd1;
  localparam logic [1:0] PH_ASYNC = 2'd2;

  // Frame list entry: base page, index bits 12:3 as word offset.
  function automatic logic [ADDR_W-1:0] frame_entry(input logic [ADDR_W-1:0] base,
                                                    input logic [FIDX_W-1:0] fidx);
    return {base[ADDR_W-1:12], fidx[12:3], 2'b00};
  endfunction

  function automatic logic [ADDR_W-1:0] link_target(input logic [ADDR_W-1:0] w);
    return {w[ADDR_W-1:LINK_LSB], {LINK_LSB{1'b0}}};
  endfunction

  function automatic logic link_end(input logic [ADDR_W-1:0] w);
    return w[0];
  endfunction
endpackage

// File: rtl/usbw_rd_tracker.sv
module usbw_rd_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic req_fire,
  input  logic rsp_valid,
  input  logic abort,
  output logic busy,
  output logic rsp_live
);
  logic out_q, stale_q, out_d, stale_d;

  always_comb begin
    out_d = out_q;
    if (req_fire)       out_d = 1'b1;
    else if (rsp_valid) out_d = 1'b0;
    stale_d = rsp_valid ? 1'b0 : stale_q;
    if (abort && (req_fire || (out_q && !rsp_valid))) stale_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q   <= 1'b0;
      stale_q <= 1'b0;
    end else begin
      out_q   <= out_d;
      stale_q <= stale_d;
    end
  end

  assign busy     = out_q;
  assign rsp_live = rsp_valid && !stale_q;
endmodule

// File: rtl/usbw_qh_ptr.sv
module usbw_qh_ptr
  import usbw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              adv_en,
  input  logic [ADDR_W-1:0] adv_data,
  output logic [ADDR_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n)      ptr <= '0;
    else if (wr_en)  ptr <= link_target(wr_data);
    else if (adv_en) ptr <= link_target(adv_data);
  end
endmodule

// File: rtl/usb_sched_walker.sv
module usb_sched_walker
  import usbw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              uframe_tick,
  input  logic              per_en,
  input  logic              async_en,
  input  logic [ADDR_W-1:0] per_base,
  input  logic [FIDX_W-1:0] frindex,
  input  logic              async_wr,
  input  logic [ADDR_W-1:0] async_wdata,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rsp_valid,
  input  logic [ADDR_W-1:0] rsp_data,
  output logic [1:0]        phase,
  output logic [ADDR_W-1:0] async_ptr
);
  walk_st_t          st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              busy, rsp_live;

  // Named events for the checker.
  logic req_fire, ev_per_end, ev_async_step;
  assign req_fire      = rd_valid && rd_ready;
  assign ev_per_end    = !uframe_tick && st_q == ST_PER_WAIT && rsp_live && link_end(rsp_data);
  assign ev_async_step = !uframe_tick && st_q == ST_ASY_WAIT && rsp_live;

  usbw_rd_tracker u_trk (
    .clk(clk), .rst_n(rst_n), .req_fire(req_fire), .rsp_valid(rsp_valid),
    .abort(uframe_tick), .busy(busy), .rsp_live(rsp_live)
  );

  usbw_qh_ptr u_qh (
    .clk(clk), .rst_n(rst_n), .wr_en(async_wr), .wr_data(async_wdata),
    .adv_en(ev_async_step), .adv_data(rsp_data), .ptr(async_ptr)
  );

  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    if (uframe_tick) begin
      if (per_en) begin
        st_d   = ST_PER_REQ;
        addr_d = frame_entry(per_base, frindex);
      end else if (async_en) begin
        st_d = ST_ASY_REQ;
      end else begin
        st_d = ST_IDLE;
      end
    end else begin
      case (st_q)
        ST_PER_REQ:  if (req_fire) st_d = ST_PER_WAIT;
        ST_PER_WAIT: if (rsp_live) begin
          if (link_end(rsp_data)) begin
            st_d = async_en ? ST_ASY_REQ : ST_IDLE;
          end else begin
            st_d   = ST_PER_REQ;
            addr_d = link_target(rsp_data);
          end
        end
        ST_ASY_REQ:  if (req_fire) st_d = ST_ASY_WAIT;
        ST_ASY_WAIT: if (rsp_live) st_d = async_en ? ST_ASY_REQ : ST_IDLE;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
    end
  end

  assign rd_valid = (st_q == ST_PER_REQ || st_q == ST_ASY_REQ) && !busy;
  assign rd_addr  = (st_q == ST_ASY_REQ) ? async_ptr : addr_q;

  always_comb begin
    case (st_q)
      ST_PER_REQ, ST_PER_WAIT: phase = PH_PER;
      ST_ASY_REQ, ST_ASY_WAIT: phase = PH_ASYNC;
      default:                 phase = PH_IDLE;
    endcase
  end
endmodule

// File: rtl/usbw_walk_chk.sv
module usbw_walk_chk
  import usbw_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              uframe_tick,
  input logic              per_en,
  input logic              async_en,
  input logic [ADDR_W-1:0] per_base,
  input logic [FIDX_W-1:0] frindex,
  input logic              async_wr,
  input logic [ADDR_W-1:0] async_wdata,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [ADDR_W-1:0] rsp_data,
  input logic [1:0]        phase,
  input logic [ADDR_W-1:0] async_ptr,
  input logic              req_fire,
  input logic              ev_per_end,
  input logic              ev_async_step
);
  AST_ENTRY_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    uframe_tick && per_en |=> phase == PH_PER && rd_addr == frame_entry($past(per_base), $past(frindex))); // R2
  AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_per_end && async_en |=> rd_valid && phase == PH_ASYNC && rd_addr == async_ptr); // R4
  AST_ASYNC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_async_step && !async_wr |=> async_ptr == {$past(rsp_data[ADDR_W-1:LINK_LSB]), {LINK_LSB{1'b0}}}); // R5
  AST_PER_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    uframe_tick && !per_en && async_en |=> phase == PH_ASYNC); // R7
  AST_IDLE_BOTH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    uframe_tick && !per_en && !async_en |=> !rd_valid && phase == PH_IDLE); // R8
  AST_WR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    async_wr |=> async_ptr == {$past(async_wdata[ADDR_W-1:LINK_LSB]), {LINK_LSB{1'b0}}}); // R9
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> !rd_valid); // R10
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready && !uframe_tick && !async_wr |=> rd_valid && $stable(rd_addr)); // R10
endmodule

bind usb_sched_walker usbw_walk_chk u_walk_chk (
  .clk(clk), .rst_n(rst_n), .uframe_tick(uframe_tick), .per_en(per_en),
  .async_en(async_en), .per_base(per_base), .frindex(frindex),
  .async_wr(async_wr), .async_wdata(async_wdata), .rd_valid(rd_valid),
  .rd_ready(rd_ready), .rd_addr(rd_addr), .rsp_data(rsp_data), .phase(phase),
  .async_ptr(async_ptr), .req_fire(req_fire), .ev_per_end(ev_per_end),
  .ev_async_step(ev_async_step)
);

// File: tb/usb_sched_walker_bench.sv
module usb_sched_walker_bench;
  localparam int CLK_T = 10;
  localparam int NVEC  = 6;
  // {base, frindex}
  localparam logic [45:0] VEC [NVEC] = '{
    {32'h1234_5000, 14'h0000}, {32'h1234_5ABC, 14'h0007},
    {32'hFFFF_F000, 14'h1FF8}, {32'h0000_1000, 14'h2008},
    {32'hA5A5_AFFF, 14'h0A50}, {32'h8000_0000, 14'h3FFF}};

  logic clk = 0, rst_n = 0, uframe_tick = 0, per_en = 0, async_en = 0;
  logic [31:0] per_base = 0, async_wdata = 0, rd_addr, rsp_data = 0, async_ptr;
  logic [13:0] frindex = 0;
  logic async_wr = 0, rd_valid, rd_ready = 1, rsp_valid = 0;
  logic [1:0] phase;

  usb_sched_walker u_usb_sched_walker (
    .clk(clk), .rst_n(rst_n), .uframe_tick(uframe_tick), .per_en(per_en),
    .async_en(async_en), .per_base(per_base), .frindex(frindex),
    .async_wr(async_wr), .async_wdata(async_wdata), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_addr(rd_addr), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .phase(phase), .async_ptr(async_ptr));

  always #(CLK_T/2) clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0, lat = 1, cnt = 0;
  bit done = 0;
  logic pend = 0;
  logic [31:0] pdata = 0;
  logic [31:0] mem [logic [31:0]];
  logic [31:0] log_a [$];
  int          log_c [$];

  function automatic logic [31:0] memrd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0000_0001;
  endfunction

  // Memory model: response lat+1 edges after the handshake.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    rsp_valid <= 1'b0;
    if (pend) begin
      if (cnt <= 1) begin rsp_valid <= 1'b1; rsp_data <= pdata; pend <= 1'b0; end
      else cnt <= cnt - 1;
    end
    if (rd_valid && rd_ready) begin
      pend <= 1'b1; cnt <= lat; pdata <= memrd(rd_addr);
      log_a.push_back(rd_addr); log_c.push_back(cyc);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tick;
    @(negedge clk) uframe_tick = 1;
    @(negedge clk) uframe_tick = 0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_T * 100000);
    nfail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    logic [31:0] p0;
    int t0;
    wait_cyc(4);
    // R1 reset state
    chk("R1 rd_valid", {31'b0, rd_valid}, 32'd0);
    chk("R1 phase", {30'b0, phase}, 32'd0);
    chk("R1 async_ptr", async_ptr, 32'd0);
    @(negedge clk) rst_n = 1;

    // R2 vector loop: frame list entry address
    per_en = 1; async_en = 0;
    for (int i = 0; i < NVEC; i++) begin
      per_base = VEC[i][45:14]; frindex = VEC[i][13:0];
      log_a.delete(); log_c.delete();
      pulse_tick();
      wait_cyc(8);
      chk("R2 count", log_a.size(), 32'd1);
      if (log_a.size() > 0)
        chk("R2 entry", log_a[0],
            (per_base & 32'hFFFF_F000) | ((32'(frindex) & 32'h0000_1FF8) >> 1));
      chk("R4 idle after end", {30'b0, phase}, 32'd0);
    end

    // R3/R4/R5/R9 chained periodic then async walk
    mem[32'h1000_0008] = 32'h2000_0042;
    mem[32'h2000_0040] = 32'h2000_0086;
    mem[32'h2000_0080] = 32'h0000_0001;
    mem[32'h3000_0000] = 32'h3000_0020;
    mem[32'h3000_0020] = 32'h3000_0000;
    @(negedge clk) begin async_wr = 1; async_wdata = 32'h3000_001F; end
    @(negedge clk) async_wr = 0;
    chk("R9 masked load", async_ptr, 32'h3000_0000);
    per_base = 32'h1000_0000; frindex = 14'h0010; async_en = 1;
    log_a.delete(); log_c.delete();
    pulse_tick();
    wait_cyc(20);
    chk("R5 phase async", {30'b0, phase}, 32'd2);
    async_en = 0;
    wait_cyc(10);
    chk("R5 stop on disable", {30'b0, phase}, 32'd0);
    if (log_a.size() >= 6) begin
      chk("R2 chain entry", log_a[0], 32'h1000_0008);
      chk("R3 link1", log_a[1], 32'h2000_0040);
      chk("R3 link2", log_a[2], 32'h2000_0080);
      chk("R4 async start", log_a[3], 32'h3000_0000);
      chk("R4 no gap", log_c[3] - log_c[2], lat + 2);
      chk("R5 follow", log_a[4], 32'h3000_0020);
      chk("R5 wrap", log_a[5], 32'h3000_0000);
    end else chk("R3 read count", log_a.size(), 32'd6);

    // R6/R11 tick during a slow outstanding async read
    lat = 3; async_en = 1; per_en = 0;
    pulse_tick();
    wait_cyc(12);
    @(negedge clk);
    while (!rd_valid) @(negedge clk);
    @(negedge clk);                 // handshake done, response pending
    p0 = async_ptr;
    per_en = 1; frindex = 14'h0038; // entry 0x1000001C, empty
    uframe_tick = 1; t0 = cyc;
    @(negedge clk) uframe_tick = 0;
    wait_cyc(20);
    begin
      int k = 0;
      while (k < log_a.size() && log_c[k] < t0) k++;
      if (k + 1 < log_a.size()) begin
        chk("R6 restart entry", log_a[k], 32'h1000_001C);
        chk("R11 stale dropped", log_a[k+1], p0);
      end else chk("R6 reads after tick", log_a.size() - k, 32'd2);
    end
    async_en = 0;
    wait_cyc(20);

    // R7 periodic disabled
    lat = 1;
    @(negedge clk) begin async_wr = 1; async_wdata = 32'h3000_0020; end
    @(negedge clk) async_wr = 0;
    chk("R9 load", async_ptr, 32'h3000_0020);
    per_en = 0; async_en = 1;
    log_a.delete(); log_c.delete();
    pulse_tick();
    chk("R7 phase", {30'b0, phase}, 32'd2);
    wait_cyc(3);
    if (log_a.size() > 0) chk("R7 first read", log_a[0], 32'h3000_0020);
    else chk("R7 read count", 32'd0, 32'd1);
    async_en = 0;
    wait_cyc(10);

    // R8 both disabled
    log_a.delete(); log_c.delete();
    pulse_tick();
    wait_cyc(10);
    chk("R8 no reads", log_a.size(), 32'd0);
    chk("R8 phase", {30'b0, phase}, 32'd0);

    // R10 stalled request holds
    rd_ready = 0; per_en = 1; per_base = 32'h4000_0000; frindex = 14'h0008;
    log_a.delete(); log_c.delete();
    pulse_tick();
    wait_cyc(5);
    chk("R10 no handshake", log_a.size(), 32'd0);
    chk("R10 valid held", {31'b0, rd_valid}, 32'd1);
    chk("R10 addr held", rd_addr, 32'h4000_0004);
    rd_ready = 1;
    @(negedge clk);
    chk("R10 single outstanding", {31'b0, rd_valid}, 32'd0);
    wait_cyc(6);
    chk("R10 accepted", log_a.size(), 32'd1);

    finish_run();
  end
endmodule